// File: doc/BRIEF.md
# ECC Error Response Controller

This block sits next to a memory subsystem. It reacts to the per-access results of an ECC decoder that serves three regions: code flash, data flash and SRAM. Each cycle the decoder may present one access with its region, its address, a flag for a corrected single-bit error and a flag for a detected double-bit error. The block decides what each event means, based on the region and on what has already happened.

Single-bit errors on flash are repaired in the data path and software is not told about them. A single-bit error in SRAM stores its address and raises an interrupt. Double-bit errors raise a machine exception. On code flash, a second uncorrectable error that arrives while the first is still unacknowledged forces a hardware reset request instead. Software reads a status word and the stored address through a small register port. It acknowledges events by writing ones to the status word.

Two state machines hold the history. The escalation machine has the states ESC_IDLE, ESC_PENDING and ESC_RESET, with these transitions:
- first_dbe: ESC_IDLE to ESC_PENDING on a code-flash double-bit error.
- ack: ESC_PENDING to ESC_IDLE when status bit 1 is written with a one.
- second_dbe: ESC_PENDING to ESC_RESET on another code-flash double-bit error.

ESC_RESET is left only by reset. The capture machine has the states CAP_OPEN and CAP_HELD, with these transitions:
- capture: CAP_OPEN to CAP_HELD on an SRAM single-bit error.
- release: CAP_HELD to CAP_OPEN when status bit 0 is written with a one.
- recapture: CAP_HELD to CAP_HELD with a new address when the release and a new SRAM single-bit error fall in the same cycle.

Top module: `ecc_resp_ctrl`

## Requirements
- R1: While and right after reset, `corr_sel`, `irq`, `mexc` and `hw_reset_req` are 0, and both the status word and the captured address read 0.
- R2: An access with `acc_valid`=1, region 0 (code flash) or region 1 (data flash), `acc_sbe`=1 and `acc_dbe`=0 drives `corr_sel`=1 in the same cycle. It changes neither the status word nor `irq`.
- R3: An SRAM access (region 2) with `acc_sbe`=1 and `acc_dbe`=0, while no address is held, sets status bit 0. From the next clock edge `cap_addr` equals the access address and `irq`=1.
- R4: While status bit 0 is set, further SRAM single-bit errors leave `cap_addr` unchanged.
- R5: Writing status (register offset 0) with bit 0 set clears status bit 0 and `irq` at the next edge. A later SRAM single-bit error is then captured again.
- R6: A code-flash access with `acc_dbe`=1 while status bit 1 is clear sets status bit 1 and `mexc` at the next edge. `hw_reset_req` stays 0.
- R7: A code-flash double-bit error while status bit 1 is set drives `hw_reset_req`=1 and status bit 4 at the next edge. Both stay set until reset.
- R8: Writing status with bit 1 set clears status bit 1 at the next edge and drops `mexc` if no other double-bit bit is set. The next code-flash double-bit error gives an exception, not a reset.
- R9: A double-bit error on data flash sets status bit 2, and one on SRAM sets status bit 3. Each sets `mexc`, and repeated ones never assert `hw_reset_req`. Writing a one to bit 2 or bit 3 clears that bit.
- R10: When `acc_sbe` and `acc_dbe` are both 1, only the double-bit response happens: `corr_sel` stays 0 and no address is captured.
- R11: Accesses with `acc_valid`=0, or with region 3, change no output and no status bit.
- R12: `reg_rdata` follows `reg_addr` in the same cycle: offset 0 returns the status word (bits 0..4 as above, all other bits 0), and offset 1 returns the captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Decoder result valid this cycle |
| acc_region | input | 2 | 0 code flash, 1 data flash, 2 SRAM, 3 unused |
| acc_addr | input | AW | Address of the access |
| acc_sbe | input | 1 | Single-bit error corrected |
| acc_dbe | input | 1 | Double-bit error detected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register offset (0 status, 1 captured address) |
| reg_wdata | input | DW | Write data; ones clear status bits |
| reg_rdata | output | DW | Read data for `reg_addr` |
| corr_sel | output | 1 | Select the corrected data path |
| cap_addr | output | AW | Captured SRAM error address |
| irq | output | 1 | Interrupt request, level |
| mexc | output | 1 | Machine exception request, level |
| hw_reset_req | output | 1 | Forced hardware reset request |

## Verification
`corr_sel` and `reg_rdata` are combinational. The bench samples them one time step after it drives the inputs, inside the same cycle. Every status bit, `cap_addr`, `irq`, `mexc` and `hw_reset_req` passes through one register. The bench drives each access or write on a falling edge, removes it on the next falling edge, and then checks these outputs, which is half a cycle after the capturing rising edge. The hold and escalation checks read again one cycle later, to show that the value persists.

// File: rtl/ecc_resp_pkg.sv
package ecc_resp_pkg;

    typedef enum logic [1:0] {
        RGN_CODE = 2'd0,
        RGN_DATA = 2'd1,
        RGN_SRAM = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ESC_IDLE    = 2'd0,
        ESC_PENDING = 2'd1,
        ESC_RESET   = 2'd2
    } esc_state_e;

    typedef enum logic {
        CAP_OPEN = 1'b0,
        CAP_HELD = 1'b1
    } cap_state_e;

    localparam int STAT_W      = 5;
    localparam int B_SRAM_SBE  = 0;
    localparam int B_CODE_DBE  = 1;
    localparam int B_DATA_DBE  = 2;
    localparam int B_SRAM_DBE  = 3;
    localparam int B_RESET     = 4;

    localparam logic OFS_STATUS = 1'b0;
    localparam logic OFS_CAPADR = 1'b1;

endpackage

// File: rtl/ecc_event_decode.sv
module ecc_event_decode
    import ecc_resp_pkg::*;
(
    input  logic       acc_valid,
    input  logic [1:0] acc_region,
    input  logic       acc_sbe,
    input  logic       acc_dbe,
    output logic       flash_fix,
    output logic       sram_sbe_ev,
    output logic       code_dbe_ev,
    output logic       data_dbe_ev,
    output logic       sram_dbe_ev
);
    region_e rgn;

    always_comb begin
        rgn         = region_e'(acc_region);
        flash_fix   = 1'b0;
        sram_sbe_ev = 1'b0;
        code_dbe_ev = 1'b0;
        data_dbe_ev = 1'b0;
        sram_dbe_ev = 1'b0;
        if (acc_valid) begin
            // double-bit handling overrides single-bit handling
            unique case (rgn)
                RGN_CODE: begin
                    code_dbe_ev = acc_dbe;
                    flash_fix   = acc_sbe && !acc_dbe;
                end
                RGN_DATA: begin
                    data_dbe_ev = acc_dbe;
                    flash_fix   = acc_sbe && !acc_dbe;
                end
                RGN_SRAM: begin
                    sram_dbe_ev = acc_dbe;
                    sram_sbe_ev = acc_sbe && !acc_dbe;
                end
                RGN_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/ecc_escalate_fsm.sv
module ecc_escalate_fsm
    import ecc_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic code_dbe_ev,
    input  logic ack,
    output logic pending,
    output logic reset_req
);
    esc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ESC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ESC_IDLE:    if (code_dbe_ev) state_d = ESC_PENDING;
            ESC_PENDING: begin
                if (code_dbe_ev) state_d = ESC_RESET;
                else if (ack)    state_d = ESC_IDLE;
            end
            ESC_RESET:   state_d = ESC_RESET;
            default:     state_d = ESC_IDLE;
        endcase
    end

    always_comb begin
        pending   = 1'b0;
        reset_req = 1'b0;
        unique case (state_q)
            ESC_IDLE:    ;
            ESC_PENDING: pending = 1'b1;
            ESC_RESET: begin
                pending   = 1'b1;
                reset_req = 1'b1;
            end
            default:     ;
        endcase
    end
endmodule

// File: rtl/ecc_capture_fsm.sv
module ecc_capture_fsm
    import ecc_resp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sram_sbe_ev,
    input  logic [AW-1:0] addr,
    input  logic          release_req,
    output logic          held,
    output logic [AW-1:0] cap_addr
);
    cap_state_e    state_q, state_d;
    logic          load;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_OPEN;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) addr_q <= addr;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            CAP_OPEN: if (sram_sbe_ev) begin
                state_d = CAP_HELD;
                load    = 1'b1;
            end
            CAP_HELD: if (release_req) begin
                if (sram_sbe_ev) load = 1'b1;
                else             state_d = CAP_OPEN;
            end
            default: state_d = CAP_OPEN;
        endcase
    end

    always_comb begin
        held     = (state_q == CAP_HELD);
        cap_addr = addr_q;
    end
endmodule

// File: rtl/ecc_resp_ctrl.sv
module ecc_resp_ctrl
    import ecc_resp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [1:0]    acc_region,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_sbe,
    input  logic          acc_dbe,
    input  logic          reg_wr,
    input  logic          reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          corr_sel,
    output logic [AW-1:0] cap_addr,
    output logic          irq,
    output logic          mexc,
    output logic          hw_reset_req
);
    logic flash_fix, sram_sbe_ev, code_dbe_ev, data_dbe_ev, sram_dbe_ev;
    logic [STAT_W-1:0] clr;
    logic cap_held, code_pend, esc_reset;
    logic data_dbe_q, sram_dbe_q;
    logic [STAT_W-1:0] status_q;

    ecc_event_decode u_dec (
        .acc_valid   (acc_valid),
        .acc_region  (acc_region),
        .acc_sbe     (acc_sbe),
        .acc_dbe     (acc_dbe),
        .flash_fix   (flash_fix),
        .sram_sbe_ev (sram_sbe_ev),
        .code_dbe_ev (code_dbe_ev),
        .data_dbe_ev (data_dbe_ev),
        .sram_dbe_ev (sram_dbe_ev)
    );

    always_comb begin
        clr = '0;
        if (reg_wr && reg_addr == OFS_STATUS) clr = reg_wdata[STAT_W-1:0];
    end

    ecc_escalate_fsm u_esc (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_dbe_ev (code_dbe_ev),
        .ack         (clr[B_CODE_DBE]),
        .pending     (code_pend),
        .reset_req   (esc_reset)
    );

    ecc_capture_fsm #(.AW(AW)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .sram_sbe_ev (sram_sbe_ev),
        .addr        (acc_addr),
        .release_req (clr[B_SRAM_SBE]),
        .held        (cap_held),
        .cap_addr    (cap_addr)
    );

    // sticky double-bit flags for regions without escalation; set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_dbe_q <= 1'b0;
            sram_dbe_q <= 1'b0;
        end else begin
            data_dbe_q <= data_dbe_ev || (data_dbe_q && !clr[B_DATA_DBE]);
            sram_dbe_q <= sram_dbe_ev || (sram_dbe_q && !clr[B_SRAM_DBE]);
        end
    end

    always_comb begin
        status_q             = '0;
        status_q[B_SRAM_SBE] = cap_held;
        status_q[B_CODE_DBE] = code_pend;
        status_q[B_DATA_DBE] = data_dbe_q;
        status_q[B_SRAM_DBE] = sram_dbe_q;
        status_q[B_RESET]    = esc_reset;
    end

    always_comb begin
        corr_sel     = flash_fix;
        irq          = cap_held;
        mexc         = code_pend || data_dbe_q || sram_dbe_q;
        hw_reset_req = esc_reset;
        reg_rdata    = '0;
        if (reg_addr == OFS_CAPADR) reg_rdata[AW-1:0]     = cap_addr;
        else                        reg_rdata[STAT_W-1:0] = status_q;
    end
endmodule

// File: rtl/ecc_resp_chk.sv
module ecc_resp_chk
    import ecc_resp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [1:0]        acc_region,
    input logic              acc_sbe,
    input logic              acc_dbe,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic              corr_sel,
    input logic [AW-1:0]     cap_addr,
    input logic              irq,
    input logic              hw_reset_req,
    input logic [STAT_W-1:0] status_q
);
    logic sbe_release;
    assign sbe_release = reg_wr && (reg_addr == OFS_STATUS) && reg_wdata[B_SRAM_SBE];

    // R7
    reset_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset_req |=> hw_reset_req);

    // R4
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !sbe_release) |=> $stable(cap_addr));

    // R2
    silent_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_sel && !reg_wr) |=> $stable(status_q));

    // R10
    dbe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_sbe && acc_dbe && acc_region == 2'd2 && !irq) |=> !irq);

    // R9
    no_escalate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_dbe && acc_region != 2'd0 && !hw_reset_req) |=> !hw_reset_req);
endmodule

bind ecc_resp_ctrl ecc_resp_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_region   (acc_region),
    .acc_sbe      (acc_sbe),
    .acc_dbe      (acc_dbe),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .corr_sel     (corr_sel),
    .cap_addr     (cap_addr),
    .irq          (irq),
    .hw_reset_req (hw_reset_req),
    .status_q     (status_q)
);

// File: tb/tb_ecc_resp_ctrl.sv
module tb_ecc_resp_ctrl;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_region = 2'd0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_sbe = 1'b0;
    logic          acc_dbe = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_addr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          corr_sel;
    logic [AW-1:0] cap_addr;
    logic          irq;
    logic          mexc;
    logic          hw_reset_req;

    int checks = 0;
    int fails  = 0;
    logic fix_seen;

    always #4 clk = ~clk;

    ecc_resp_ctrl #(.AW(AW), .DW(DW)) dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] rg, input logic [AW-1:0] a,
                          input logic s, input logic d, input logic v = 1'b1);
        @(negedge clk);
        acc_valid = v; acc_region = rg; acc_addr = a; acc_sbe = s; acc_dbe = d;
        #1 fix_seen = corr_sel;
        @(negedge clk);
        acc_valid = 1'b0; acc_sbe = 1'b0; acc_dbe = 1'b0;
    endtask

    task automatic clear(input logic [DW-1:0] m);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = m;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    function automatic logic [31:0] rd(input logic a);
        reg_addr = a;
        return 32'(reg_rdata);
    endfunction

    task automatic read(input logic a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        chk("R1 irq", irq, 0);
        chk("R1 mexc", mexc, 0);
        chk("R1 hw_reset_req", hw_reset_req, 0);
        chk("R1 corr_sel", corr_sel, 0);
        read(1'b0, v); chk("R1 status", v, 0);
        read(1'b1, v); chk("R1 cap_addr", v, 0);
    endtask

    task automatic t_flash_fix();
        logic [31:0] v;
        access(2'd0, 32'h100, 1'b1, 1'b0);
        chk("R2 corr_sel code", fix_seen, 1);
        access(2'd1, 32'h104, 1'b1, 1'b0);
        chk("R2 corr_sel data", fix_seen, 1);
        chk("R2 irq", irq, 0);
        read(1'b0, v); chk("R2 status", v, 0);
        access(2'd2, 32'h108, 1'b1, 1'b0);
        chk("R2 corr_sel sram", fix_seen, 0);
        clear(32'h1f);
    endtask

    task automatic t_sram_capture();
        logic [31:0] v;
        access(2'd2, 32'hA5A0_0010, 1'b1, 1'b0);
        chk("R3 irq", irq, 1);
        chk("R3 cap_addr", cap_addr, 32'hA5A0_0010);
        read(1'b0, v); chk("R3 status bit0", v, 32'h1);
        read(1'b1, v); chk("R12 read cap", v, 32'hA5A0_0010);
        access(2'd2, 32'h0000_0BAD, 1'b1, 1'b0);
        chk("R4 held cap_addr", cap_addr, 32'hA5A0_0010);
        @(negedge clk);
        chk("R4 still held", cap_addr, 32'hA5A0_0010);
        clear(32'h1);
        chk("R5 irq cleared", irq, 0);
        access(2'd2, 32'h0000_2222, 1'b1, 1'b0);
        chk("R5 recapture", cap_addr, 32'h0000_2222);
        chk("R5 irq again", irq, 1);
        clear(32'h1);
    endtask

    task automatic t_code_escalate();
        logic [31:0] v;
        access(2'd0, 32'h40, 1'b0, 1'b1);
        chk("R6 mexc", mexc, 1);
        chk("R6 no reset", hw_reset_req, 0);
        read(1'b0, v); chk("R6 status", v, 32'h2);
        clear(32'h2);
        chk("R8 mexc dropped", mexc, 0);
        read(1'b0, v); chk("R8 status", v, 0);
        access(2'd0, 32'h44, 1'b0, 1'b1);
        chk("R8 rearmed mexc", mexc, 1);
        chk("R8 rearmed no reset", hw_reset_req, 0);
        access(2'd0, 32'h48, 1'b0, 1'b1);
        chk("R7 reset req", hw_reset_req, 1);
        read(1'b0, v); chk("R7 status bit4", v[4], 1);
        clear(32'h1f);
        chk("R7 reset held", hw_reset_req, 1);
        do_reset();
        chk("R1 reset clears escalation", hw_reset_req, 0);
    endtask

    task automatic t_other_dbe();
        logic [31:0] v;
        access(2'd1, 32'h80, 1'b0, 1'b1);
        chk("R9 data mexc", mexc, 1);
        access(2'd1, 32'h84, 1'b0, 1'b1);
        access(2'd2, 32'h88, 1'b0, 1'b1);
        access(2'd2, 32'h8C, 1'b0, 1'b1);
        chk("R9 no reset", hw_reset_req, 0);
        read(1'b0, v); chk("R9 status", v, 32'hC);
        clear(32'h4);
        read(1'b0, v); chk("R9 clear bit2", v, 32'h8);
        clear(32'h8);
        chk("R9 mexc off", mexc, 0);
    endtask

    task automatic t_both_flags();
        logic [31:0] v;
        access(2'd2, 32'h300, 1'b1, 1'b1);
        chk("R10 no capture irq", irq, 0);
        read(1'b0, v); chk("R10 status", v, 32'h8);
        access(2'd0, 32'h304, 1'b1, 1'b1);
        chk("R10 corr_sel off", fix_seen, 0);
        chk("R10 code mexc", mexc, 1);
        clear(32'h1f);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        access(2'd3, 32'h500, 1'b1, 1'b1);
        chk("R11 region3 corr_sel", fix_seen, 0);
        read(1'b0, v); chk("R11 region3 status", v, 0);
        access(2'd2, 32'h504, 1'b1, 1'b1, 1'b0);
        access(2'd0, 32'h508, 1'b1, 1'b0, 1'b0);
        chk("R11 invalid corr_sel", fix_seen, 0);
        read(1'b0, v); chk("R11 invalid status", v, 0);
        chk("R11 outputs", {irq, mexc, hw_reset_req}, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_flash_fix();
        t_sram_capture();
        t_code_escalate();
        t_other_dbe();
        t_both_flags();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule